// File: doc/BRIEF.md
# Cache-Line Bus Master with Burst Fallback

This block is the bus-facing side of a processor's line fill and line write path. A requester hands it one 16-byte cache line, made of four 32-bit longwords, together with a direction flag. The block then moves that line over an external bus. It always opens the transfer as a line-size burst. If the target accepts the burst, the four longwords follow one another under a single address phase. If the target cannot burst, it says so in the cycle that acknowledges the first longword. The block then completes the line as three separate longword cycles, each with its own address phase.

In both cases the requester sees the same result. On a write, the same four longwords reach the bus in the same order. On a read, the line buffer holds the same 128-bit value. A one-cycle done pulse marks completion, and the block takes a new line only when it is idle. The requester passes a line number rather than a byte address, so every address the block puts on the bus is line-aligned by construction.

Top module: `line_burst_master`

## Requirements
- R1: One cycle after a request is accepted, `bus_start` is high for that cycle, with `bus_addr` = `req_line` × 16, `bus_size` = 1 (line), and `bus_write` = `req_write`.
- R2: If `bus_binh` is low on the first acknowledge, no further `bus_start` occurs for that line. Each later `bus_ack` moves the next longword, and the fourth acknowledge ends the line. An acknowledge counts in any cycle from the `bus_start` cycle onward, including that cycle itself.
- R3: If `bus_binh` is high on the first acknowledge, `bus_start` is raised in the next cycle with `bus_size` = 0 (longword) at line base + 4. After the acknowledge of each such single cycle, the next one starts in the following cycle, at +8 and then at +12.
- R4: `bus_binh` has no effect on any acknowledge except the first one of the line-size cycle, and no effect while idle.
- R5: On a write, at the k-th acknowledge (k = 0..3), `bus_wdata` equals `req_wdata[32k+31:32k]`. This holds in both burst and fallback modes.
- R6: On a read, after the line completes, `rsp_rdata[32k+31:32k]` holds the `bus_rdata` that was present at the k-th acknowledge. The value is identical in burst and fallback modes.
- R7: `rsp_done` is high for exactly one cycle: the cycle after the fourth acknowledge. It is low at all other times.
- R8: A `req_valid` that arrives while a line is in progress is ignored. A request that arrives in the `rsp_done` cycle is accepted.
- R9: After reset, `bus_start` and `rsp_done` are low, and `bus_ack` has no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write line to bus, 0 = read line |
| req_line | input | AW-4 | Line number (byte address divided by 16) |
| req_wdata | input | 128 | Line to write, longword 0 in the low bits |
| rsp_rdata | output | 128 | Line buffer, longword 0 in the low bits |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_addr | output | AW | Bus address of the current address phase |
| bus_start | output | 1 | Address phase strobe |
| bus_size | output | 1 | 1 = line (burst), 0 = single longword |
| bus_write | output | 1 | Direction of the current transfer |
| bus_wdata | output | 32 | Longword driven for the current beat |
| bus_rdata | input | 32 | Longword returned by the target |
| bus_ack | input | 1 | Transfer acknowledge for one longword |
| bus_binh | input | 1 | Burst inhibit, sampled with the first acknowledge |

## Verification
Lines are run against a target that accepts bursts and against one that raises the inhibit on the first beat. Each case is run for reads and for writes, with zero-wait and multi-cycle acknowledge spacing. Running both modes separates the burst path from the fallback path in address sequence, size code and strobe timing, while the data checks show that both paths give the same line. A noisy target raises inhibit on later beats to show that those samples are ignored. Requests raised mid-line and in the done cycle separate busy rejection from back-to-back acceptance.

// File: rtl/line_xfer_pkg.sv
package line_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BURST  = 2'd1,
    ST_SINGLE = 2'd2
  } xfer_state_t;

  localparam logic SZ_LONG = 1'b0;
  localparam logic SZ_LINE = 1'b1;

endpackage

// File: rtl/lx_seq.sv
module lx_seq
  import line_xfer_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int IDXW  = $clog2(BEATS),
  localparam int WOFFW = $clog2(DW / 8),
  localparam int OFFW  = IDXW + WOFFW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-OFFW-1:0]   req_line,
  input  logic                 bus_ack,
  input  logic                 bus_binh,
  output logic [AW-1:0]        bus_addr,
  output logic                 bus_start,
  output logic                 bus_size,
  output logic                 bus_write,
  output logic [IDXW-1:0]      beat_idx,
  output logic                 beat_take,
  output logic                 busy,
  output logic                 rsp_done
);

  xfer_state_t          state_q;
  logic [AW-OFFW-1:0]   line_q;
  logic [IDXW-1:0]      idx_nx;
  logic                 last_beat;
  logic                 first_beat;
  logic [AW-1:0]        step_addr;

  assign busy       = (state_q != ST_IDLE);
  assign beat_take  = busy && bus_ack;
  assign idx_nx     = beat_idx + IDXW'(1);
  assign last_beat  = (beat_idx == IDXW'(BEATS - 1));
  assign first_beat = (beat_idx == '0);
  assign step_addr  = {line_q, idx_nx, {WOFFW{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      line_q    <= '0;
      beat_idx  <= '0;
      bus_addr  <= '0;
      bus_start <= 1'b0;
      bus_size  <= SZ_LINE;
      bus_write <= 1'b0;
      rsp_done  <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      rsp_done  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            line_q    <= req_line;
            bus_addr  <= {req_line, {OFFW{1'b0}}};
            bus_start <= 1'b1;
            bus_size  <= SZ_LINE;
            bus_write <= req_write;
            beat_idx  <= '0;
            state_q   <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (beat_take) begin
            if (first_beat && bus_binh) begin
              state_q   <= ST_SINGLE;
              beat_idx  <= idx_nx;
              bus_start <= 1'b1;
              bus_size  <= SZ_LONG;
              bus_addr  <= step_addr;
            end else if (last_beat) begin
              state_q  <= ST_IDLE;
              rsp_done <= 1'b1;
            end else begin
              beat_idx <= idx_nx;
            end
          end
        end
        ST_SINGLE: begin
          if (beat_take) begin
            if (last_beat) begin
              state_q  <= ST_IDLE;
              rsp_done <= 1'b1;
            end else begin
              beat_idx  <= idx_nx;
              bus_start <= 1'b1;
              bus_addr  <= step_addr;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_LINE_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (bus_start && bus_size == SZ_LINE) |-> (bus_addr[OFFW-1:0] == '0)); // R1

  AST_BURST_NO_READDRESS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BURST && beat_take && !bus_binh) |=> !bus_start); // R2

  AST_SINGLE_NOT_WORD0: assert property (@(posedge clk) disable iff (rst)
    (bus_start && bus_size == SZ_LONG) |-> (bus_addr[OFFW-1:0] != '0)); // R3

  AST_LATE_INHIBIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BURST && !first_beat && beat_take) |=> !bus_start); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R7

endmodule

// File: rtl/lx_linebuf.sv
module lx_linebuf #(
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int IDXW = $clog2(BEATS),
  localparam int LW   = DW * BEATS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LW-1:0]    load_line,
  input  logic             beat_take,
  input  logic             bus_write,
  input  logic [IDXW-1:0]  beat_idx,
  input  logic [DW-1:0]    bus_rdata,
  output logic [LW-1:0]    line_flat,
  output logic [DW-1:0]    bus_wdata
);

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (load) begin
        word_q <= load_line[g*DW +: DW];
      end else if (beat_take && !bus_write && beat_idx == IDXW'(g)) begin
        word_q <= bus_rdata;
      end
    end
    assign line_flat[g*DW +: DW] = word_q;
  end

  assign bus_wdata = line_flat[beat_idx*DW +: DW];

  AST_WRITE_KEEPS_LINE: assert property (@(posedge clk) disable iff (rst)
    (beat_take && bus_write) |=> $stable(line_flat)); // R5

endmodule

// File: rtl/line_burst_master.sv
module line_burst_master
  import line_xfer_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int LW   = DW * BEATS,
  localparam int OFFW = $clog2(LW / 8),
  localparam int IDXW = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [AW-OFFW-1:0] req_line,
  input  logic [LW-1:0]      req_wdata,
  output logic [LW-1:0]      rsp_rdata,
  output logic               rsp_done,
  output logic [AW-1:0]      bus_addr,
  output logic               bus_start,
  output logic               bus_size,
  output logic               bus_write,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  input  logic               bus_ack,
  input  logic               bus_binh
);

  logic            busy;
  logic            beat_take;
  logic [IDXW-1:0] beat_idx;
  logic            load;

  assign load = req_valid && !busy;

  lx_seq #(.AW(AW), .DW(DW), .BEATS(BEATS)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_line  (req_line),
    .bus_ack   (bus_ack),
    .bus_binh  (bus_binh),
    .bus_addr  (bus_addr),
    .bus_start (bus_start),
    .bus_size  (bus_size),
    .bus_write (bus_write),
    .beat_idx  (beat_idx),
    .beat_take (beat_take),
    .busy      (busy),
    .rsp_done  (rsp_done)
  );

  lx_linebuf #(.DW(DW), .BEATS(BEATS)) i_buf (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_line (req_wdata),
    .beat_take (beat_take),
    .bus_write (bus_write),
    .beat_idx  (beat_idx),
    .bus_rdata (bus_rdata),
    .line_flat (rsp_rdata),
    .bus_wdata (bus_wdata)
  );

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> !(bus_start && bus_size == SZ_LINE)); // R8

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(bus_ack)); // R7

endmodule

// File: tb/test_line_burst_master.sv
`timescale 1ns/1ps
module test_line_burst_master;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-5:0] req_line = '0;
  logic [LW-1:0] req_wdata = '0;
  logic [LW-1:0] rsp_rdata;
  logic rsp_done;
  logic [AW-1:0] bus_addr;
  logic bus_start, bus_size, bus_write;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_ack = 1'b0, bus_binh = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  line_burst_master i_line_burst_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_line(req_line), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .bus_addr(bus_addr), .bus_start(bus_start),
    .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_binh(bus_binh)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  // Behavioural model of one line: a queue of expected address phases,
  // a count of acknowledged longwords, and the expected done cycle.
  task automatic run_line(input bit wr, input logic [AW-5:0] line,
                          input bit inh, input int wt, input bit noise,
                          input bit poke);
    logic [AW-1:0] base;
    logic [LW-1:0] wline, rline;
    logic [AW-1:0] ph_addr[$];
    bit            ph_size[$];
    bit exp_start, exp_done, phase_open, poked;
    int k, cnt, guard;
    string tag;
    base  = {line, 4'h0};
    wline = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < 4; i++) rline[i*32 +: 32] = $urandom;
    req_valid = 1'b1; req_write = wr; req_line = line; req_wdata = wline;
    ph_addr.push_back(base); ph_size.push_back(1'b1);
    exp_start = 1'b1; exp_done = 1'b0; phase_open = 1'b0; poked = 1'b0;
    k = 0; cnt = 0; guard = 0;
    while (1) begin
      @(negedge clk);
      req_valid = 1'b0;
      guard++;
      tag = poked ? "R8" : (noise && k > 0) ? "R4" : (k == 0) ? "R1" : inh ? "R3" : "R2";
      poked = 1'b0;
      chk(bus_start == exp_start, tag, "bus_start", LW'(bus_start), LW'(exp_start));
      if (exp_start && bus_start && ph_addr.size() > 0) begin
        logic [AW-1:0] ea;
        bit es;
        ea = ph_addr.pop_front(); es = ph_size.pop_front();
        chk(bus_addr == ea, (k == 0) ? "R1" : "R3", "bus_addr", LW'(bus_addr), LW'(ea));
        chk(bus_size == es, (k == 0) ? "R1" : "R3", "bus_size", LW'(bus_size), LW'(es));
        chk(bus_write == wr, "R1", "bus_write", LW'(bus_write), LW'(wr));
        phase_open = 1'b1; cnt = 0;
      end
      exp_start = 1'b0;
      chk(rsp_done == exp_done, "R7", "rsp_done", LW'(rsp_done), LW'(exp_done));
      if (exp_done) break;
      if (guard > 200) begin
        chk(1'b0, "R2", "line never completed", LW'(k), LW'(4));
        break;
      end
      if (poke && k == 1) begin
        req_valid = 1'b1; req_write = ~wr; req_line = line + 7; poked = 1'b1;
      end
      bus_ack  = 1'b0;
      bus_binh = noise ? 1'($urandom) : 1'b0;
      if (phase_open && cnt >= wt && k < 4) begin
        bus_ack   = 1'b1;
        bus_binh  = (k == 0) ? inh : (noise ? 1'b1 : 1'b0);
        bus_rdata = rline[k*32 +: 32];
        if (wr) chk(bus_wdata == wline[k*32 +: 32], "R5", "bus_wdata",
                    LW'(bus_wdata), LW'(wline[k*32 +: 32]));
        k++;
        if (k == 4) begin
          exp_done = 1'b1; phase_open = 1'b0;
        end else if (inh) begin
          exp_start = 1'b1; phase_open = 1'b0;
          ph_addr.push_back(base + AW'(4 * k)); ph_size.push_back(1'b0);
        end else begin
          cnt = 0;
        end
      end else begin
        cnt++;
      end
    end
    bus_ack = 1'b0; bus_binh = 1'b0;
    if (!wr) chk(rsp_rdata == rline, "R6", "rsp_rdata", rsp_rdata, rline);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(bus_start == 1'b0, "R9", "bus_start after reset", LW'(bus_start), '0);
    chk(rsp_done == 1'b0, "R9", "rsp_done after reset", LW'(rsp_done), '0);
    // acknowledge and inhibit while idle must do nothing
    for (int i = 0; i < 4; i++) begin
      bus_ack = 1'b1; bus_binh = i[0];
      @(negedge clk);
      chk(bus_start == 1'b0 && rsp_done == 1'b0, "R9", "idle ack",
          LW'({bus_start, rsp_done}), '0);
    end
    bus_ack = 1'b0; bus_binh = 1'b0;
    run_line(1'b1, 28'h0000100, 1'b0, 0, 1'b0, 1'b0); // R2 R5 burst write
    run_line(1'b0, 28'h0000200, 1'b0, 2, 1'b0, 1'b0); // R2 R6 burst read
    run_line(1'b1, 28'h0000300, 1'b1, 0, 1'b0, 1'b0); // R3 R5 fallback write
    run_line(1'b0, 28'hABCDEF1, 1'b1, 1, 1'b0, 1'b0); // R3 R6 fallback read
    run_line(1'b0, 28'h0000400, 1'b0, 1, 1'b1, 1'b0); // R4 late inhibit, burst
    run_line(1'b1, 28'h0000500, 1'b1, 0, 1'b1, 1'b1); // R4 R8 fallback
    run_line(1'b0, 28'h0000600, 1'b0, 3, 1'b0, 1'b1); // R8 busy request
    for (int i = 0; i < 24; i++)
      run_line(1'($urandom), 28'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
               1'($urandom), 1'($urandom));
    @(negedge clk);
    chk(rsp_done == 1'b0 && bus_start == 1'b0, "R7", "quiet after last line",
        LW'({bus_start, rsp_done}), '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule